// File: doc/BRIEF.md
# Serial Identification Code CRC Checker

This block takes a 64-bit identification code one bit per accepted strobe, least significant bit first, and checks it against an 8-bit cyclic redundancy code with generator x^8 + x^5 + x^4 + 1. The code is made of three fields in a fixed order: an 8-bit family byte, a 48-bit serial number, and an 8-bit CRC over the first 56 bits. Because the CRC bits are fed through the same register as the data, an intact code leaves an all-zero remainder after the last bit.

A frame begins on a valid bit that carries the start marker. From then on, every valid bit updates the remainder and advances a bit counter. After the 64th bit the block raises a done level and, in the same cycle, a pass flag when the remainder is zero. Once the first eight bits are in, it also reports whether the family byte equals the expected value, 04h by default. A clear input aborts any frame and returns the block to idle. All outputs are registered.

Top module: `idcrc_check`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `rem_o` is 00h and `done_o`, `pass_o` and `family_ok_o` are 0.
- R2: For each accepted bit b, with fb = b XOR rem[0], the next remainder is (rem >> 1) XOR (fb ? 8Ch : 00h). On a bit with the start marker, rem is taken as 00h. The result shows on `rem_o` one clock after the bit is sampled.
- R3: A cycle with `bit_vld_i` low changes no output, whatever value `bit_i` and `sof_i` hold.
- R4: After the 56th bit of a frame (family byte, then serial number, each LSB first), `rem_o` equals the CRC of those 56 bits.
- R5: `done_o` is 0 during a frame and rises one clock after the 64th accepted bit. It then stays high, and further valid bits without a start marker are ignored, until a start marker or a clear.
- R6: `pass_o` rises together with `done_o` exactly when the remainder after 64 bits is 00h. While `pass_o` is high, `rem_o` is 00h.
- R7: One clock after the 8th bit of a frame, `family_ok_o` is 1 exactly when those eight bits, taken LSB first, equal the expected family byte (04h). It holds that value until a start marker or a clear.
- R8: `clr_i` high takes priority over every other input. It sets `rem_o` to 00h and clears `done_o`, `pass_o`, `family_ok_o` and the bit counter.
- R9: While no frame is active (after reset, after a clear, or after done), valid bits without a start marker leave `rem_o` unchanged.
- R10: A valid bit with the start marker that arrives in the middle of a frame restarts the frame. That bit becomes bit 0 and is folded into a zero remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Abort frame and clear all state |
| sof_i | input | 1 | Marks the current valid bit as bit 0 of a new code |
| bit_vld_i | input | 1 | Strobe: `bit_i` is accepted this cycle |
| bit_i | input | 1 | Serial code bit, LSB first |
| rem_o | output | 8 | Running CRC remainder |
| done_o | output | 1 | All 64 bits received |
| pass_o | output | 1 | Final remainder was zero |
| family_ok_o | output | 1 | First byte matched the expected family code |

## Verification
The properties assume that the start marker matters only when it comes together with a valid strobe, and that `rst` is high from time zero until the first clock edges have passed. The stimulus always drives `sof_i` with `bit_vld_i` on a frame's first bit. It deliberately inserts gap cycles in which `bit_i` and `sof_i` toggle with the strobe low, so that the hold properties see inputs that would otherwise matter. The clear is applied together with a valid start-marked bit, which tests its priority over every other input.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;

  // Per-cycle control strobes produced by the frame sequencer.
  typedef struct packed {
    logic take;      // a code bit is consumed this cycle
    logic first;     // that bit is bit 0 of a new frame
    logic fam_last;  // that bit closes the family field
    logic code_last; // that bit closes the whole code
  } idcrc_ctl_t;

endpackage

// File: rtl/idcrc_seq.sv
module idcrc_seq
  import idcrc_pkg::*;
#(
  parameter int CODE_BITS   = 64,
  parameter int FAMILY_BITS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       sof_i,
  input  logic       bit_vld_i,
  output idcrc_ctl_t ctl_o,
  output logic       done_q_o
);
  localparam int CNT_W = $clog2(CODE_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             active_q;
  logic             done_q;

  // The clear masks every strobe so that it wins over start and valid.
  always_comb begin
    ctl_o.first     = bit_vld_i && sof_i && !clr_i;
    ctl_o.take      = bit_vld_i && !clr_i && (sof_i || active_q);
    idx             = ctl_o.first ? '0 : cnt_q;
    ctl_o.fam_last  = ctl_o.take && (idx == CNT_W'(FAMILY_BITS - 1));
    ctl_o.code_last = ctl_o.take && (idx == CNT_W'(CODE_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (ctl_o.take) begin
      cnt_q    <= idx + CNT_W'(1);
      active_q <= !ctl_o.code_last;
      done_q   <= ctl_o.code_last;
    end
  end

  assign done_q_o = done_q;
endmodule

// File: rtl/idcrc_lfsr.sv
module idcrc_lfsr #(
  parameter int             REM_W     = 8,
  parameter logic [REM_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             first_i,
  input  logic             din_i,
  output logic [REM_W-1:0] rem_q_o,
  output logic [REM_W-1:0] rem_nxt_o
);
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] seed;
  logic             fb;

  assign seed = first_i ? '0 : rem_q;
  assign fb   = din_i ^ seed[0];

  // Right shift with the feedback bit entering at the top, and the
  // reflected polynomial taps XORed in wherever the constant has a one.
  for (genvar i = 0; i < REM_W; i++) begin : g_tap
    if (i == REM_W - 1) begin : g_top
      assign rem_nxt_o[i] = POLY_REFL[i] & fb;
    end else begin : g_mid
      assign rem_nxt_o[i] = seed[i+1] ^ (POLY_REFL[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      rem_q <= '0;
    end else if (take_i) begin
      rem_q <= rem_nxt_o;
    end
  end

  assign rem_q_o = rem_q;
endmodule

// File: rtl/idcrc_family.sv
module idcrc_family #(
  parameter int               FAMILY_BITS = 8,
  parameter logic [FAMILY_BITS-1:0] FAMILY_CODE = 8'h04
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic take_i,
  input  logic first_i,
  input  logic last_i,
  input  logic din_i,
  output logic ok_q_o
);
  logic [FAMILY_BITS-1:0] sh_q;
  logic [FAMILY_BITS-1:0] sh_nxt;
  logic                   ok_q;

  // LSB-first capture: each new bit enters at the top and moves down.
  generate
    if (FAMILY_BITS == 1) begin : g_one
      assign sh_nxt = din_i;
    end else begin : g_many
      assign sh_nxt = {din_i, (first_i ? {(FAMILY_BITS-1){1'b0}}
                                       : sh_q[FAMILY_BITS-1:1])};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sh_q <= '0;
      ok_q <= 1'b0;
    end else if (take_i) begin
      sh_q <= sh_nxt;
      if (last_i) begin
        ok_q <= (sh_nxt == FAMILY_CODE);
      end else if (first_i) begin
        ok_q <= 1'b0;
      end
    end
  end

  assign ok_q_o = ok_q;
endmodule

// File: rtl/idcrc_check.sv
module idcrc_check
  import idcrc_pkg::*;
#(
  parameter int               CODE_BITS   = 64,
  parameter int               FAMILY_BITS = 8,
  parameter int               REM_W       = 8,
  parameter logic [REM_W-1:0] POLY_REFL   = 8'h8C,
  parameter logic [FAMILY_BITS-1:0] FAMILY_CODE = 8'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             sof_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [REM_W-1:0] rem_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             family_ok_o
);
  idcrc_ctl_t       ctl;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_nxt;
  logic             done_q;
  logic             pass_q;
  logic             fam_q;

  idcrc_seq #(
    .CODE_BITS  (CODE_BITS),
    .FAMILY_BITS(FAMILY_BITS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .sof_i    (sof_i),
    .bit_vld_i(bit_vld_i),
    .ctl_o    (ctl),
    .done_q_o (done_q)
  );

  idcrc_lfsr #(
    .REM_W    (REM_W),
    .POLY_REFL(POLY_REFL)
  ) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .take_i   (ctl.take),
    .first_i  (ctl.first),
    .din_i    (bit_i),
    .rem_q_o  (rem_q),
    .rem_nxt_o(rem_nxt)
  );

  idcrc_family #(
    .FAMILY_BITS(FAMILY_BITS),
    .FAMILY_CODE(FAMILY_CODE)
  ) u_family (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .take_i (ctl.take),
    .first_i(ctl.first),
    .last_i (ctl.fam_last),
    .din_i  (bit_i),
    .ok_q_o (fam_q)
  );

  // The verdict is registered on the same edge as the last remainder update.
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pass_q <= 1'b0;
    end else if (ctl.take) begin
      pass_q <= ctl.code_last && (rem_nxt == '0);
    end
  end

  assign rem_o       = rem_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign family_ok_o = fam_q;
endmodule

// File: rtl/idcrc_check_chk.sv
module idcrc_check_chk #(
  parameter int               REM_W     = 8,
  parameter logic [REM_W-1:0] POLY_REFL = 8'h8C
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             sof_i,
  input logic             bit_vld_i,
  input logic             bit_i,
  input logic [REM_W-1:0] rem_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             family_ok_o
);
  // R8
  clr_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (rem_o == '0) && !done_o && !pass_o && !family_ok_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld_i && !clr_i) |=> $stable(rem_o) && $stable(done_o)
                               && $stable(pass_o) && $stable(family_ok_o));

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_i && sof_i && !clr_i) |=>
      (rem_o == ($past(bit_i) ? POLY_REFL : '0)) && !done_o);

  // R6
  pass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o && (rem_o == '0));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clr_i && !(bit_vld_i && sof_i)) |=>
      done_o && $stable(rem_o) && $stable(pass_o));

  // R7
  family_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (family_ok_o && !clr_i && !(bit_vld_i && sof_i)) |=> family_ok_o);
endmodule

bind idcrc_check idcrc_check_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .sof_i      (sof_i),
  .bit_vld_i  (bit_vld_i),
  .bit_i      (bit_i),
  .rem_o      (rem_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .family_ok_o(family_ok_o)
);

// File: tb/idcrc_check_tb.sv
module idcrc_check_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       sof = 1'b0;
  logic       vld = 1'b0;
  logic       din = 1'b0;
  logic [7:0] rem;
  logic       done;
  logic       pass;
  logic       fam_ok;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idcrc_check u_dut (
    .clk(clk), .rst(rst), .clr_i(clr), .sof_i(sof), .bit_vld_i(vld),
    .bit_i(din), .rem_o(rem), .done_o(done), .pass_o(pass),
    .family_ok_o(fam_ok)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference shift, written from the register picture: the feedback
  // bit goes to the top and flips stages 3 and 2.
  function automatic logic [7:0] step(input logic [7:0] r, input logic b);
    logic fb;
    logic [7:0] n;
    fb = b ^ r[0];
    n = {fb, r[7:1]};
    n[3] = n[3] ^ fb;
    n[2] = n[2] ^ fb;
    return n;
  endfunction

  function automatic logic [7:0] crc56(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 56; i++) r = step(r, d[i]);
    return r;
  endfunction

  // Called at a falling edge; drives one cycle and returns at the next one.
  task automatic cyc(input logic v, input logic b, input logic s);
    vld = v; din = b; sof = s;
    @(negedge clk);
    vld = 1'b0; sof = 1'b0;
  endtask

  task automatic run_frame(input logic [63:0] code, input int seed,
                           input bit exp_pass, input string tag0);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 64; i++) begin
      if (i > 0 && ((i * 7 + seed) % 5 == 0)) begin
        logic [7:0] hold = rem;
        cyc(1'b0, ~code[i], 1'b1);
        chk(rem == hold, "R3", "gap rem", rem, hold);
      end
      cyc(1'b1, code[i], i == 0);
      r = step(r, code[i]);
      chk(rem == r, (i == 0) ? tag0 : "R2", "rem", rem, r);
      if (i == 7)
        chk(fam_ok == (code[7:0] == 8'h04), "R7", "family_ok", fam_ok,
            code[7:0] == 8'h04);
      if (i == 55)
        chk(rem == crc56(code[55:0]), "R4", "crc at 56", rem, crc56(code[55:0]));
      if (i < 63) chk(done == 1'b0, "R5", "done early", done, 0);
    end
    chk(done == 1'b1, "R5", "done", done, 1);
    chk(pass == exp_pass, "R6", "pass", pass, exp_pass);
    chk(pass == (r == 8'h00), "R6", "pass vs rem", pass, r == 8'h00);
    cyc(1'b1, 1'b1, 1'b0);
    chk(rem == r && done == 1'b1, "R5", "post-done bit", rem, r);
    chk(fam_ok == (code[7:0] == 8'h04), "R7", "family_ok held", fam_ok,
        code[7:0] == 8'h04);
  endtask

  function automatic logic [63:0] make_code(input logic [7:0] f,
                                            input logic [47:0] s);
    return {crc56({s, f}), s, f};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] good;
    repeat (3) @(negedge clk);
    chk(rem == 8'h00 && !done && !pass && !fam_ok, "R1", "in reset",
        {rem, done, pass, fam_ok}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rem == 8'h00 && !done && !pass && !fam_ok, "R1", "after reset",
        {rem, done, pass, fam_ok}, 0);

    // R9: bits before any start marker are ignored
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 1'b1, 1'b0);
      chk(rem == 8'h00 && !done, "R9", "idle bit", rem, 0);
    end

    // Every family byte with a well-formed code
    for (int f = 0; f < 256; f++) begin
      logic [47:0] s = 48'h5A3C0F1E2D4B * 48'(f + 1);
      run_frame(make_code(8'(f), s), f, 1'b1, "R2");
    end

    // Every single-bit corruption of a family-04h code must fail
    good = make_code(8'h04, 48'h0000_1234_ABCD);
    for (int p = 0; p < 64; p++) begin
      logic [63:0] bad = good ^ (64'd1 << p);
      run_frame(bad, p, 1'b0, "R2");
    end

    // R10: start marker in the middle of a frame restarts it
    cyc(1'b1, 1'b1, 1'b1);
    for (int k = 1; k < 30; k++) cyc(1'b1, k[0], 1'b0);
    run_frame(good, 3, 1'b1, "R10");

    // R8: clear beats a simultaneous start-marked valid bit
    cyc(1'b1, 1'b0, 1'b1);
    for (int k = 1; k < 20; k++) cyc(1'b1, k[1], 1'b0);
    clr = 1'b1;
    cyc(1'b1, 1'b1, 1'b1);
    clr = 1'b0;
    chk(rem == 8'h00 && !done && !pass && !fam_ok, "R8", "mid clear",
        {rem, done, pass, fam_ok}, 0);
    cyc(1'b1, 1'b1, 1'b0);
    chk(rem == 8'h00, "R9", "bit after clear", rem, 0);

    // R8: clear after a passing frame drops the verdict
    run_frame(good, 1, 1'b1, "R2");
    clr = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    clr = 1'b0;
    chk(rem == 8'h00 && !done && !pass && !fam_ok, "R8", "clear after done",
        {rem, done, pass, fam_ok}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule